// File: doc/BRIEF.md
# Trap and Interrupt Entry Unit

This block owns a processor's status word and the control-flow change that happens when a trap is taken. It tracks which interrupt sources are pending, decides whether one of them interrupts the instruction about to issue, and on any trap saves the mode state into single-level "previous" bits. It also records the faulting program counter and a cause code, steers the program counter to the exception vector, and pulses a request to drop any outstanding load reservation.

Synchronous exceptions come from the execution pipeline as a request plus a small cause code and apply to the instruction at the current program counter. Interrupts are considered only at an instruction boundary, when `issue` is high. When an exception and an interrupt meet in the same cycle, the exception is taken. Software changes the status word through a write port. The pending-interrupt field of that word is owned by the set and clear inputs and cannot be written.

The status word layout is: bit 0 supervisor, bit 1 previous supervisor, bit 2 global interrupt enable, bit 3 previous enable, bit 4 user 64-bit mode, bit 5 supervisor 64-bit mode, bit 6 floating-point enable, bit 7 accelerator enable, bits 8 to 8+N-1 interrupt mask, bits 8+N to 8+2N-1 interrupt pending, with N the number of interrupt sources (8 by default). All higher bits read as zero.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x2000 and `status` has only bit 0 set, plus bit 5 when 64-bit support is configured (the default). `epc`, `evec` and `cause` are zero and `resv_clear` is low.
- R2: An interrupt is taken only in a cycle with `issue` high, status bit 2 set, and for some index i both the pending bit 8+N+i and the mask bit 8+i set.
- R3: When several interrupts qualify, the one with the lowest index is taken.
- R4: An interrupt writes `cause` as its index with a flag bit added. The flag is at bit 63 when status bit 5 is set and at bit 31 otherwise. An exception writes `cause` as `exc_code` zero-extended.
- R5: On a trap, status bit 0 becomes 1 and bit 2 becomes 0. Bit 1 takes the old bit 0, bit 3 takes the old bit 2, and every other status bit is unchanged by the trap.
- R6: On a trap, `epc` takes the current `pc` and `pc` takes the value `evec` held before that clock edge. Both values appear after that edge.
- R7: A status write leaves the pending field unchanged. Pending bit i is cleared by `irq_clr[i]` and set by `irq_set[i]`, with set winning when both are high. This holds in every cycle, including trap cycles.
- R8: A status write stores `sr_wdata` with these bits forced to zero: bits 4 and 5 without 64-bit support, bit 6 without a floating-point unit (default: absent), bit 7 without an accelerator (default: absent), and every bit above the pending field.
- R9: `resv_clear` is high for exactly the cycle after each clock edge that takes a trap, and low otherwise.
- R10: An exception is taken in preference to an interrupt in the same cycle. A status write in a trap cycle is ignored.
- R11: Without a trap, `pc` takes `issue_next_pc` when `issue` is high and holds otherwise. `evec` takes `evec_wdata` whenever `evec_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_set | input | NUM_IRQ | Per-source request to set a pending bit |
| irq_clr | input | NUM_IRQ | Per-source request to clear a pending bit |
| issue | input | 1 | Instruction boundary: the instruction at `pc` is about to issue |
| issue_next_pc | input | XLEN | Program counter after the issuing instruction |
| exc_req | input | 1 | Synchronous exception for the instruction at `pc` |
| exc_code | input | CODE_W | Exception cause code |
| sr_we | input | 1 | Status write enable |
| sr_wdata | input | XLEN | Status write data |
| evec_we | input | 1 | Exception vector write enable |
| evec_wdata | input | XLEN | Exception vector write data |
| pc | output | XLEN | Current / next program counter |
| status | output | XLEN | Status word |
| epc | output | XLEN | Saved program counter of the last trap |
| evec | output | XLEN | Exception vector |
| cause | output | XLEN | Cause of the last trap |
| resv_clear | output | 1 | One-cycle pulse releasing the load reservation |

## Verification
Directed sequences cover several cases. One write of all ones shows which status bits survive masking. Two pending sources that both qualify separate lowest-index priority from other orderings. Repeating an interrupt with the 64-bit mode bit cleared tells the bit-63 flag apart from the bit-31 flag. An exception raised together with a qualifying interrupt and a status write shows exception priority and the dropped write. A long random phase then mixes sparse set and clear pulses, status writes with random enables and masks, vector writes, and exceptions against a behavioural model. This exposes wrong previous-bit pushes, pending bits lost to writes, and a redirect to the wrong vector value when the vector is written in the trap cycle.

// File: rtl/trap_pkg.sv
// Package: trap_pkg
// Bit positions of the fixed fields of the status word shared by the
// trap entry unit, its submodules and its checker. The mask and pending
// fields follow these bits and are sized by the NUM_IRQ parameter.
package trap_pkg;
    localparam int SR_SUP     = 0;
    localparam int SR_PSUP    = 1;
    localparam int SR_GIE     = 2;
    localparam int SR_PGIE    = 3;
    localparam int SR_U64     = 4;
    localparam int SR_S64     = 5;
    localparam int SR_FPEN    = 6;
    localparam int SR_ACCEN   = 7;
    localparam int SR_IM_LSB  = 8;
endpackage

// File: rtl/trap_irq_arbiter.sv
// Module: trap_irq_arbiter
// Qualifies pending interrupts against their masks and the global enable
// and picks the lowest-numbered one. Assumes NUM_IRQ >= 2. Purely
// combinational; the take signal is only meaningful at an issue boundary.
module trap_irq_arbiter #(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] pending,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic               gie,
    input  logic               issue,
    output logic               take,
    output logic [NUM_IRQ-1:0] grant,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_IRQ-1:0] qual;
    logic [NUM_IRQ-1:0] lower_any;

    // Qualify each source by its mask and the global enable.
    assign qual = pending & mask & {NUM_IRQ{gie}};

    // Priority chain: a source wins only if no lower source qualifies.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        if (i == 0) begin : g_first
            assign lower_any[i] = 1'b0;
        end else begin : g_rest
            assign lower_any[i] = lower_any[i-1] | qual[i-1];
        end
        assign grant[i] = qual[i] & ~lower_any[i];
    end

    // Encode the one-hot grant into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

    // An interrupt is taken only at an instruction boundary.
    assign take = issue & (|qual);
endmodule

// File: rtl/trap_status_reg.sv
// Module: trap_status_reg
// Holds the status word. A trap pushes supervisor and enable into their
// previous bits; otherwise a software write stores the masked data. The
// pending field is owned by the set/clear inputs in every cycle.
// Assumes 8 + 2*NUM_IRQ <= XLEN.
module trap_status_reg
    import trap_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int NUM_IRQ   = 8,
    parameter bit HAS_RV64  = 1'b1,
    parameter bit HAS_FPU   = 1'b0,
    parameter bit HAS_ACCEL = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap,
    input  logic               sr_we,
    input  logic [XLEN-1:0]    sr_wdata,
    input  logic [NUM_IRQ-1:0] irq_set,
    input  logic [NUM_IRQ-1:0] irq_clr,
    output logic [XLEN-1:0]    status
);
    localparam int IP_LSB = SR_IM_LSB + NUM_IRQ;

    // Builds the set of bits that software may write.
    function automatic logic [XLEN-1:0] write_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[SR_SUP]   = 1'b1;
        m[SR_PSUP]  = 1'b1;
        m[SR_GIE]   = 1'b1;
        m[SR_PGIE]  = 1'b1;
        m[SR_U64]   = HAS_RV64;
        m[SR_S64]   = HAS_RV64;
        m[SR_FPEN]  = HAS_FPU;
        m[SR_ACCEN] = HAS_ACCEL;
        m[SR_IM_LSB +: NUM_IRQ] = '1;
        return m;
    endfunction

    // Builds the value of the status word out of reset.
    function automatic logic [XLEN-1:0] reset_value();
        logic [XLEN-1:0] r;
        r = '0;
        r[SR_SUP] = 1'b1;
        r[SR_S64] = HAS_RV64;
        return r;
    endfunction

    localparam logic [XLEN-1:0] WMASK    = write_mask();
    localparam logic [XLEN-1:0] RESET_SR = reset_value();

    logic [XLEN-1:0]    sr_q;
    logic [XLEN-1:0]    sr_d;
    logic [NUM_IRQ-1:0] pend_q;

    assign pend_q = sr_q[IP_LSB +: NUM_IRQ];

    // Next status: trap push, else masked write, then pending update.
    always_comb begin
        sr_d = sr_q;
        if (trap) begin
            sr_d[SR_SUP]  = 1'b1;
            sr_d[SR_PSUP] = sr_q[SR_SUP];
            sr_d[SR_GIE]  = 1'b0;
            sr_d[SR_PGIE] = sr_q[SR_GIE];
        end else if (sr_we) begin
            sr_d = sr_wdata & WMASK;
        end
        sr_d[IP_LSB +: NUM_IRQ] = (pend_q & ~irq_clr) | irq_set;
    end

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= RESET_SR;
        else        sr_q <= sr_d;
    end

    assign status = sr_q;
endmodule

// File: rtl/trap_ctx_regs.sv
// Module: trap_ctx_regs
// Program counter, saved PC, exception vector, cause and the reservation
// release pulse. On a trap the PC is steered to the vector value held
// before the edge, so a same-cycle vector write affects later traps only.
module trap_ctx_regs #(
    parameter int              XLEN     = 64,
    parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h2000)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap,
    input  logic [XLEN-1:0] trap_cause,
    input  logic            issue,
    input  logic [XLEN-1:0] issue_next_pc,
    input  logic            evec_we,
    input  logic [XLEN-1:0] evec_wdata,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] evec,
    output logic [XLEN-1:0] cause,
    output logic            resv_clear
);
    logic [XLEN-1:0] pc_q, epc_q, evec_q, cause_q;
    logic            resv_q;

    // Program counter: vector on trap, next PC on issue, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= RESET_PC;
        else if (trap)  pc_q <= evec_q;
        else if (issue) pc_q <= issue_next_pc;
    end

    // Saved PC and cause are captured only on trap entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (trap) begin
            epc_q   <= pc_q;
            cause_q <= trap_cause;
        end
    end

    // Exception vector is loaded by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)       evec_q <= '0;
        else if (evec_we) evec_q <= evec_wdata;
    end

    // Reservation release follows each trap edge by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) resv_q <= 1'b0;
        else        resv_q <= trap;
    end

    assign pc         = pc_q;
    assign epc        = epc_q;
    assign evec       = evec_q;
    assign cause      = cause_q;
    assign resv_clear = resv_q;
endmodule

// File: rtl/trap_entry_unit.sv
// Module: trap_entry_unit
// Top of the trap and interrupt entry unit. Decides whether a trap is taken
// this cycle (exception first, then the lowest qualifying interrupt at an
// issue boundary), forms its cause code and drives the state registers.
// Assumes XLEN >= 32, NUM_IRQ >= 2 and CODE_W < XLEN.
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int NUM_IRQ   = 8,
    parameter int CODE_W    = 5,
    parameter bit HAS_RV64  = 1'b1,
    parameter bit HAS_FPU   = 1'b0,
    parameter bit HAS_ACCEL = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_set,
    input  logic [NUM_IRQ-1:0] irq_clr,
    input  logic               issue,
    input  logic [XLEN-1:0]    issue_next_pc,
    input  logic               exc_req,
    input  logic [CODE_W-1:0]  exc_code,
    input  logic               sr_we,
    input  logic [XLEN-1:0]    sr_wdata,
    input  logic               evec_we,
    input  logic [XLEN-1:0]    evec_wdata,
    output logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    status,
    output logic [XLEN-1:0]    epc,
    output logic [XLEN-1:0]    evec,
    output logic [XLEN-1:0]    cause,
    output logic               resv_clear
);
    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int IP_LSB = SR_IM_LSB + NUM_IRQ;

    logic               irq_take;
    logic [NUM_IRQ-1:0] irq_grant;
    logic [IDX_W-1:0]   irq_idx;
    logic               trap_fire;
    logic [XLEN-1:0]    trap_cause;
    logic [XLEN-1:0]    irq_flag;

    trap_irq_arbiter #(.NUM_IRQ(NUM_IRQ)) arb_i (
        .pending (status[IP_LSB +: NUM_IRQ]),
        .mask    (status[SR_IM_LSB +: NUM_IRQ]),
        .gie     (status[SR_GIE]),
        .issue   (issue),
        .take    (irq_take),
        .grant   (irq_grant),
        .idx     (irq_idx)
    );

    // A trap is an exception or an interrupt taken at the boundary.
    assign trap_fire = exc_req | irq_take;

    // Interrupt flag bit sits at the top of the current mode's width.
    always_comb begin
        irq_flag = '0;
        if (status[SR_S64]) irq_flag[XLEN-1] = 1'b1;
        else                irq_flag[31]     = 1'b1;
    end

    // Cause: exception code wins over the interrupt index.
    always_comb begin
        if (exc_req) trap_cause = {{(XLEN-CODE_W){1'b0}}, exc_code};
        else         trap_cause = irq_flag | {{(XLEN-IDX_W){1'b0}}, irq_idx};
    end

    trap_status_reg #(
        .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .HAS_RV64(HAS_RV64),
        .HAS_FPU(HAS_FPU), .HAS_ACCEL(HAS_ACCEL)
    ) sr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap     (trap_fire),
        .sr_we    (sr_we),
        .sr_wdata (sr_wdata),
        .irq_set  (irq_set),
        .irq_clr  (irq_clr),
        .status   (status)
    );

    trap_ctx_regs #(.XLEN(XLEN)) ctx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trap          (trap_fire),
        .trap_cause    (trap_cause),
        .issue         (issue),
        .issue_next_pc (issue_next_pc),
        .evec_we       (evec_we),
        .evec_wdata    (evec_wdata),
        .pc            (pc),
        .epc           (epc),
        .evec          (evec),
        .cause         (cause),
        .resv_clear    (resv_clear)
    );
endmodule

// File: rtl/trap_entry_chk.sv
// Module: trap_entry_chk
// Assertion checker bound to trap_entry_unit. Observes the ports and the
// trap decision signals; drives nothing.
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NUM_IRQ = 8,
    parameter int CODE_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap_fire,
    input logic               irq_take,
    input logic [NUM_IRQ-1:0] irq_grant,
    input logic               exc_req,
    input logic [CODE_W-1:0]  exc_code,
    input logic [NUM_IRQ-1:0] irq_set,
    input logic [NUM_IRQ-1:0] irq_clr,
    input logic [XLEN-1:0]    pc,
    input logic [XLEN-1:0]    status,
    input logic [XLEN-1:0]    epc,
    input logic [XLEN-1:0]    evec,
    input logic [XLEN-1:0]    cause,
    input logic               resv_clear
);
    localparam int IP_LSB = SR_IM_LSB + NUM_IRQ;

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> status[SR_GIE]); // R2
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_grant)); // R3
    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> cause == {{(XLEN-CODE_W){1'b0}}, $past(exc_code)}); // R10
    AST_TRAP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> status[SR_SUP] && !status[SR_GIE]
                      && status[SR_PSUP] == $past(status[SR_SUP])
                      && status[SR_PGIE] == $past(status[SR_GIE])); // R5
    AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> pc == $past(evec) && epc == $past(pc)); // R6
    AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set == '0 && irq_clr == '0) |=> $stable(status[IP_LSB +: NUM_IRQ])); // R7
    AST_RESV_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> resv_clear); // R9
    AST_RESV_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_fire |=> !resv_clear); // R9
endmodule

bind trap_entry_unit trap_entry_chk #(
    .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .CODE_W(CODE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_fire  (trap_fire),
    .irq_take   (irq_take),
    .irq_grant  (irq_grant),
    .exc_req    (exc_req),
    .exc_code   (exc_code),
    .irq_set    (irq_set),
    .irq_clr    (irq_clr),
    .pc         (pc),
    .status     (status),
    .epc        (epc),
    .evec       (evec),
    .cause      (cause),
    .resv_clear (resv_clear)
);

// File: tb/trap_entry_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for trap_entry_unit: behavioural reference model compared every
// clock, plus directed scenarios with hand-computed expectations.
module trap_entry_unit_tb_top;
    localparam int XLEN = 64;
    localparam int N    = 8;
    localparam int CW   = 5;
    localparam logic [63:0] WMASK = 64'h0000_0000_0000_FF3F;
    localparam logic [63:0] IPM   = 64'h0000_0000_00FF_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_set = '0, irq_clr = '0;
    logic            issue = 1'b0;
    logic [XLEN-1:0] issue_next_pc = '0;
    logic            exc_req = 1'b0;
    logic [CW-1:0]   exc_code = '0;
    logic            sr_we = 1'b0;
    logic [XLEN-1:0] sr_wdata = '0;
    logic            evec_we = 1'b0;
    logic [XLEN-1:0] evec_wdata = '0;
    logic [XLEN-1:0] pc, status, epc, evec, cause;
    logic            resv_clear;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_pc, m_sr, m_epc, m_evec, m_cause;
    logic        m_resv;

    always #2 clk = ~clk;

    trap_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .irq_clr(irq_clr),
        .issue(issue), .issue_next_pc(issue_next_pc), .exc_req(exc_req),
        .exc_code(exc_code), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .evec_we(evec_we), .evec_wdata(evec_wdata), .pc(pc), .status(status),
        .epc(epc), .evec(evec), .cause(cause), .resv_clear(resv_clear)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R6 R11 pc", pc, m_pc);
        check("R5 R7 R8 status", status, m_sr);
        check("R6 epc", epc, m_epc);
        check("R11 evec", evec, m_evec);
        check("R2 R3 R4 R10 cause", cause, m_cause);
        check("R9 resv_clear", {63'd0, resv_clear}, {63'd0, m_resv});
    endtask

    task automatic clear_inputs();
        irq_set = '0; irq_clr = '0; issue = 0; exc_req = 0; exc_code = '0;
        sr_we = 0; sr_wdata = '0; evec_we = 0; evec_wdata = '0;
        issue_next_pc = '0;
    endtask

    // One clock: model next state from current inputs, advance, compare.
    task automatic step_cycle();
        logic [63:0] n_pc, n_sr, n_epc, n_evec, n_cause;
        logic [7:0]  ip, q;
        int          win;
        bit          take, trap;
        ip = m_sr[23:16];
        q  = ip & m_sr[15:8];
        take = issue && m_sr[2] && (q != 0) && !exc_req;
        trap = exc_req || take;
        win = 0;
        for (int i = N - 1; i >= 0; i--) if (q[i]) win = i;
        n_pc = m_pc; n_sr = m_sr; n_epc = m_epc; n_evec = m_evec; n_cause = m_cause;
        if (trap) begin
            n_sr[0] = 1'b1; n_sr[1] = m_sr[0];
            n_sr[2] = 1'b0; n_sr[3] = m_sr[2];
            n_epc = m_pc;
            n_pc = m_evec;
            if (exc_req) n_cause = 64'(exc_code);
            else n_cause = (m_sr[5] ? (64'd1 << 63) : (64'd1 << 31)) + 64'(win);
        end else begin
            if (sr_we) n_sr = (sr_wdata & WMASK) | (m_sr & IPM);
            if (issue) n_pc = issue_next_pc;
        end
        n_sr[23:16] = (ip & ~irq_clr) | irq_set;
        if (evec_we) n_evec = evec_wdata;
        @(posedge clk);
        m_pc = n_pc; m_sr = n_sr; m_epc = n_epc; m_evec = n_evec;
        m_cause = n_cause; m_resv = trap;
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        #600000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        clear_inputs();
        repeat (3) @(negedge clk);
        // R1: reset values while rst_n is low
        check("R1 pc", pc, 64'h2000);
        check("R1 status", status, 64'h21);
        check("R1 epc", epc, 64'h0);
        check("R1 evec", evec, 64'h0);
        check("R1 cause", cause, 64'h0);
        check("R1 resv_clear", {63'd0, resv_clear}, 64'h0);
        m_pc = 64'h2000; m_sr = 64'h21; m_epc = 0; m_evec = 0; m_cause = 0; m_resv = 0;
        rst_n = 1'b1;

        // R11: vector write, then issue advances pc
        evec_we = 1; evec_wdata = 64'h8000;
        step_cycle(); clear_inputs();
        issue = 1; issue_next_pc = 64'h2004;
        step_cycle(); clear_inputs();
        check("R11 pc advance", pc, 64'h2004);

        // R8: write all ones; bits 6,7 and upper bits are forced to zero
        sr_we = 1; sr_wdata = '1;
        step_cycle(); clear_inputs();
        check("R8 masked write", status, 64'hFF3F);

        // R2: pending 2 and 5 without issue -> no trap
        irq_set = 8'b0010_0100;
        step_cycle(); clear_inputs();
        step_cycle();
        check("R2 no take without issue", pc, 64'h2004);
        // R7: status write keeps pending field
        sr_we = 1; sr_wdata = 64'hFF3F;
        step_cycle(); clear_inputs();
        check("R7 pending kept", status, 64'h24FF3F);

        // R3/R4: lowest index 2 taken, 64-bit flag
        issue = 1; issue_next_pc = 64'h2008;
        step_cycle(); clear_inputs();
        check("R3 R4 cause", cause, 64'h8000_0000_0000_0002);
        check("R6 redirect", pc, 64'h8000);
        check("R6 epc", epc, 64'h2004);
        check("R9 pulse", {63'd0, resv_clear}, 64'h1);
        irq_clr = 8'b0000_0100;
        step_cycle(); clear_inputs();
        check("R9 pulse ends", {63'd0, resv_clear}, 64'h0);

        // R4/R5: 32-bit flag with mode bit 5 clear; previous-bit push
        sr_we = 1; sr_wdata = 64'hFF04;
        step_cycle(); clear_inputs();
        issue = 1; issue_next_pc = 64'h9000;
        step_cycle(); clear_inputs();
        check("R4 cause 32-bit flag", cause, 64'h0000_0000_8000_0005);
        check("R5 status push", status, 64'h20FF09);

        // R10: exception plus qualifying interrupt plus status write
        sr_we = 1; sr_wdata = 64'hFF04;
        step_cycle(); clear_inputs();
        exc_req = 1; exc_code = 5'd13; issue = 1;
        sr_we = 1; sr_wdata = 64'h0;
        step_cycle(); clear_inputs();
        check("R10 exception cause", cause, 64'd13);
        check("R10 write ignored", status, 64'h20FF09);

        // Random phase against the model
        for (int k = 0; k < 4000; k++) begin
            irq_set = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
            irq_clr = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
            issue = $urandom_range(0, 1) == 1;
            issue_next_pc = {$urandom, $urandom} & ~64'h3;
            exc_req = $urandom_range(0, 15) == 0;
            exc_code = CW'($urandom);
            sr_we = $urandom_range(0, 9) == 0;
            sr_wdata = {$urandom, $urandom} | (($urandom_range(0, 1) == 1) ? 64'h4 : 64'h0);
            evec_we = $urandom_range(0, 19) == 0;
            evec_wdata = {$urandom, $urandom};
            step_cycle();
        end
        clear_inputs();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule